// File: doc/BRIEF.md
# Multiframe S/Q Bit Buffer

This block sits between a line framer and a host processor. The framer hands over five received S-channel bits once per multiframe. The block holds them in a read-only status word, together with three event flags: new S data has arrived, the Q buffer is empty, and the multiframe sync state has changed. On the transmit side the host writes four Q-channel bits and one fallback bit. The framer takes the Q bits at each multiframe boundary.

While multiframing is enabled and the framer reports no multiframe sync, every Q slot presented to the framer carries the fallback bit. A mode input lets each of the three event flags drive a single interrupt line. That line stays asserted for as long as any enabled flag is set.

Host access is a plain read strobe for the status word and a plain write strobe for the Q buffer. Address decoding is done outside the block.

Top module: `mfb_sq_buffer`

## Requirements
- R1: After reset, status_o reads 0x40 (only bit 6, Q-empty, set), q_o reads 4'b1111 with mode_i[0]=0, the stored fallback bit is 0, and irq_o is 0 with mode_i bits 3:1 clear.
- R2: A cycle with s_cap_i high stores s_bits_i into status_o bits 4:0, where bit 0 is S1 and bit 4 is S5. The new value is visible after that clock edge.
- R3: Status bit 5 (S data available) sets on a capture. It clears after a cycle with stat_rd_i high that has no capture; when a read and a capture fall in the same cycle, the capture wins.
- R4: Status bit 7 (change of state) sets after any clock edge where sync_i differs from the value sampled at the previous edge; the sync history resets to 0. A read without a transition clears it, and a transition wins over a read in the same cycle.
- R5: Status bit 6 (Q buffer empty) clears after a cycle with q_wr_i high and sets after a cycle with q_take_i high and no write. A write and a take in the same cycle leave the buffer full.
- R6: A write stores q_wdata_i bits 3:0 as Q1..Q4, which appear on q_o bits 3:0. Bit 4 is stored as the fallback value. Bits 7:5 are ignored.
- R7: While mode_i[0]=1 (multiframing enabled) and sync_i=0, every bit of q_o equals the fallback bit. Otherwise q_o shows the stored Q1..Q4.
- R8: irq_o is the OR of three terms: bit 5 AND mode_i[2], bit 6 AND mode_i[1], and bit 7 AND mode_i[3]. The S bits 4:0 never affect it.
- R9: irq_o stays high for as long as an enabled flag stays set. It drops after the cycle that clears the last such flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| s_cap_i | input | 1 | Framer strobe: S bits of a finished multiframe are valid |
| s_bits_i | input | 5 | Received S1..S5 (bit 0 = S1) |
| sync_i | input | 1 | Framer multiframe sync indication |
| q_take_i | input | 1 | Framer consumes the Q bits at a multiframe boundary |
| q_o | output | 4 | Q1..Q4 presented to the framer (bit 0 = Q1) |
| mode_i | input | 4 | Bit 0 multiframing enable, bits 1..3 interrupt enables |
| stat_rd_i | input | 1 | Host read strobe for the status word |
| status_o | output | 8 | Status word: S bits, available, Q-empty, change of state |
| q_wr_i | input | 1 | Host write strobe for the Q buffer |
| q_wdata_i | input | 8 | Write data: Q1..Q4 in bits 3:0, fallback in bit 4 |
| irq_o | output | 1 | Interrupt request |

## Verification
Directed sequences first cover the same-cycle conflicts: read against capture, read against a sync edge, and write against take. Each sequence shows whether set or clear wins for that flag. Interrupt sequences then enable one mode bit at a time, which tells apart which flag drives the line and shows that it holds until the clearing cycle. A long random phase draws every strobe, sync_i and mode_i independently each cycle. Sync loss is drawn both with multiframing on and with it off, so the fallback substitution is separated from the stored Q bits. Every output is compared with a bench model each cycle.

// File: rtl/mfb_pkg.sv
package mfb_pkg;
  // positions of the event flags above the S field, relative to the S width
  localparam int unsigned FLG_AVAIL = 0;
  localparam int unsigned FLG_EMPTY = 1;
  localparam int unsigned FLG_COS   = 2;
  localparam int unsigned N_FLG     = 3;

  // mode bit assignments
  localparam int unsigned MODE_MF_EN   = 0;
  localparam int unsigned MODE_EMPTY_E = 1;
  localparam int unsigned MODE_AVAIL_E = 2;
  localparam int unsigned MODE_COS_E   = 3;
  localparam int unsigned MODE_W       = 4;

  typedef struct packed {
    logic cos;
    logic empty;
    logic avail;
  } mfb_flags_t;
endpackage

// File: rtl/mfb_rx_status.sv
module mfb_rx_status #(
  parameter int unsigned S_W = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cap_i,
  input  logic [S_W-1:0] s_i,
  input  logic           sync_i,
  input  logic           rd_i,
  output logic [S_W-1:0] s_o,
  output logic           avail_o,
  output logic           cos_o
);
  logic [S_W-1:0] s_q;
  logic           avail_q;
  logic           cos_q;
  logic           sync_q;
  logic           sync_edge;

  assign sync_edge = sync_i ^ sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q     <= '0;
      avail_q <= 1'b0;
      cos_q   <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      sync_q <= sync_i;
      if (cap_i) begin
        s_q     <= s_i;
        avail_q <= 1'b1;
      end else if (rd_i) begin
        avail_q <= 1'b0;
      end
      // a sync edge outranks the clearing read
      if (sync_edge)  cos_q <= 1'b1;
      else if (rd_i)  cos_q <= 1'b0;
    end
  end

  assign s_o     = s_q;
  assign avail_o = avail_q;
  assign cos_o   = cos_q;
endmodule

// File: rtl/mfb_tx_qbuf.sv
module mfb_tx_qbuf #(
  parameter int unsigned Q_W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [Q_W-1:0] q_i,
  input  logic           fb_i,
  input  logic           take_i,
  input  logic           mf_en_i,
  input  logic           sync_i,
  output logic [Q_W-1:0] q_o,
  output logic           empty_o
);
  logic [Q_W-1:0] q_q;
  logic           fb_q;
  logic           empty_q;
  logic           use_fb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q     <= '1;
      fb_q    <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      if (wr_i) begin
        q_q     <= q_i;
        fb_q    <= fb_i;
        empty_q <= 1'b0;
      end else if (take_i) begin
        empty_q <= 1'b1;
      end
    end
  end

  assign use_fb = mf_en_i & ~sync_i;

  for (genvar i = 0; i < Q_W; i++) begin : g_slot
    assign q_o[i] = use_fb ? fb_q : q_q[i];
  end

  assign empty_o = empty_q;
endmodule

// File: rtl/mfb_irq_gate.sv
module mfb_irq_gate
  import mfb_pkg::*;
(
  input  mfb_flags_t         flags_i,
  input  logic [N_FLG-1:0]   en_i,
  output logic               irq_o
);
  logic [N_FLG-1:0] flg_vec;
  logic [N_FLG-1:0] hit;

  assign flg_vec = flags_i;

  for (genvar i = 0; i < N_FLG; i++) begin : g_src
    assign hit[i] = flg_vec[i] & en_i[i];
  end

  assign irq_o = |hit;
endmodule

// File: rtl/mfb_sq_buffer.sv
module mfb_sq_buffer
  import mfb_pkg::*;
#(
  parameter int unsigned S_W    = 5,
  parameter int unsigned Q_W    = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_cap_i,
  input  logic [S_W-1:0]    s_bits_i,
  input  logic              sync_i,
  input  logic              q_take_i,
  output logic [Q_W-1:0]    q_o,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              stat_rd_i,
  output logic [DATA_W-1:0] status_o,
  input  logic              q_wr_i,
  input  logic [DATA_W-1:0] q_wdata_i,
  output logic              irq_o
);
  localparam int unsigned STAT_USED = S_W + N_FLG;
  localparam int unsigned FB_POS    = Q_W;

  logic [S_W-1:0]   s_cur;
  mfb_flags_t       flags;
  logic [N_FLG-1:0] irq_en;

  mfb_rx_status #(.S_W(S_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (s_cap_i),
    .s_i     (s_bits_i),
    .sync_i  (sync_i),
    .rd_i    (stat_rd_i),
    .s_o     (s_cur),
    .avail_o (flags.avail),
    .cos_o   (flags.cos)
  );

  mfb_tx_qbuf #(.Q_W(Q_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (q_wr_i),
    .q_i     (q_wdata_i[Q_W-1:0]),
    .fb_i    (q_wdata_i[FB_POS]),
    .take_i  (q_take_i),
    .mf_en_i (mode_i[MODE_MF_EN]),
    .sync_i  (sync_i),
    .q_o     (q_o),
    .empty_o (flags.empty)
  );

  assign irq_en[FLG_AVAIL] = mode_i[MODE_AVAIL_E];
  assign irq_en[FLG_EMPTY] = mode_i[MODE_EMPTY_E];
  assign irq_en[FLG_COS]   = mode_i[MODE_COS_E];

  mfb_irq_gate u_irq (
    .flags_i (flags),
    .en_i    (irq_en),
    .irq_o   (irq_o)
  );

  assign status_o[S_W-1:0]             = s_cur;
  assign status_o[S_W+FLG_AVAIL]       = flags.avail;
  assign status_o[S_W+FLG_EMPTY]       = flags.empty;
  assign status_o[S_W+FLG_COS]         = flags.cos;
  if (DATA_W > STAT_USED) begin : g_pad
    assign status_o[DATA_W-1:STAT_USED] = '0;
  end
endmodule

// File: rtl/mfb_sq_buffer_chk.sv
module mfb_sq_buffer_chk
  import mfb_pkg::*;
#(
  parameter int unsigned S_W    = 5,
  parameter int unsigned Q_W    = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_cap_i,
  input logic [S_W-1:0]    s_bits_i,
  input logic              sync_i,
  input logic              q_take_i,
  input logic [Q_W-1:0]    q_o,
  input logic [MODE_W-1:0] mode_i,
  input logic              stat_rd_i,
  input logic [DATA_W-1:0] status_o,
  input logic              q_wr_i,
  input logic [DATA_W-1:0] q_wdata_i,
  input logic              irq_o
);
  localparam int unsigned P_AV = S_W + FLG_AVAIL;
  localparam int unsigned P_EM = S_W + FLG_EMPTY;
  localparam int unsigned P_CS = S_W + FLG_COS;

  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_cap_i |=> status_o[S_W-1:0] == $past(s_bits_i));

  a_r3_avail_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_cap_i |=> status_o[P_AV]);

  a_r3_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !s_cap_i) |=> !status_o[P_AV]);

  a_r4_cos_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i != $past(sync_i)) |=> status_o[P_CS]);

  a_r5_write_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_wr_i |=> !status_o[P_EM]);

  a_r5_take_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_take_i && !q_wr_i) |=> status_o[P_EM]);

  a_r7_fallback_uniform: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[MODE_MF_EN] && !sync_i) |-> (q_o == '0 || q_o == '1));

  a_r8_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((status_o[P_AV] & mode_i[MODE_AVAIL_E]) |
              (status_o[P_EM] & mode_i[MODE_EMPTY_E]) |
              (status_o[P_CS] & mode_i[MODE_COS_E])));

  a_r9_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !stat_rd_i && !q_wr_i && $stable(mode_i)) |=> irq_o || !$stable(mode_i));
endmodule

bind mfb_sq_buffer mfb_sq_buffer_chk #(.S_W(S_W), .Q_W(Q_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .s_cap_i   (s_cap_i),
  .s_bits_i  (s_bits_i),
  .sync_i    (sync_i),
  .q_take_i  (q_take_i),
  .q_o       (q_o),
  .mode_i    (mode_i),
  .stat_rd_i (stat_rd_i),
  .status_o  (status_o),
  .q_wr_i    (q_wr_i),
  .q_wdata_i (q_wdata_i),
  .irq_o     (irq_o)
);

// File: tb/mfb_sq_buffer_test.sv
module mfb_sq_buffer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       s_cap_i = 1'b0;
  logic [4:0] s_bits_i = '0;
  logic       sync_i = 1'b0;
  logic       q_take_i = 1'b0;
  logic [3:0] q_o;
  logic [3:0] mode_i = '0;
  logic       stat_rd_i = 1'b0;
  logic [7:0] status_o;
  logic       q_wr_i = 1'b0;
  logic [7:0] q_wdata_i = '0;
  logic       irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // bench model
  logic [4:0] m_s;
  logic       m_av, m_em, m_cos, m_fb, m_sh;
  logic [3:0] m_q;

  always #5 clk_i = ~clk_i;

  mfb_sq_buffer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .s_cap_i(s_cap_i), .s_bits_i(s_bits_i),
    .sync_i(sync_i), .q_take_i(q_take_i), .q_o(q_o), .mode_i(mode_i),
    .stat_rd_i(stat_rd_i), .status_o(status_o), .q_wr_i(q_wr_i),
    .q_wdata_i(q_wdata_i), .irq_o(irq_o)
  );

  function automatic logic [7:0] exp_status();
    return {m_cos, m_em, m_av, m_s};
  endfunction

  function automatic logic [3:0] exp_q();
    return (mode_i[0] && !sync_i) ? {4{m_fb}} : m_q;
  endfunction

  function automatic logic exp_irq();
    return (m_av & mode_i[2]) | (m_em & mode_i[1]) | (m_cos & mode_i[3]);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [7:0] es;
    es = exp_status();
    chk("R2 S bits", {3'b0, status_o[4:0]}, {3'b0, es[4:0]});
    chk("R3 avail", {7'b0, status_o[5]}, {7'b0, es[5]});
    chk("R5 empty", {7'b0, status_o[6]}, {7'b0, es[6]});
    chk("R4 cos", {7'b0, status_o[7]}, {7'b0, es[7]});
    chk("R6 R7 q_o", {4'b0, q_o}, {4'b0, exp_q()});
    chk("R8 R9 irq", {7'b0, irq_o}, {7'b0, exp_irq()});
  endtask

  task automatic model_reset();
    m_s = '0; m_av = 0; m_em = 1; m_cos = 0; m_fb = 0; m_sh = 0; m_q = 4'hf;
  endtask

  task automatic model_edge();
    if (sync_i != m_sh) m_cos = 1;
    else if (stat_rd_i) m_cos = 0;
    m_sh = sync_i;
    if (s_cap_i) begin m_s = s_bits_i; m_av = 1; end
    else if (stat_rd_i) m_av = 0;
    if (q_wr_i) begin m_q = q_wdata_i[3:0]; m_fb = q_wdata_i[4]; m_em = 0; end
    else if (q_take_i) m_em = 1;
  endtask

  // called at a negedge: drive, pass one edge, check
  task automatic cyc(logic cap, logic [4:0] s, logic rd, logic wr, logic [7:0] wd,
                     logic take, logic sy, logic [3:0] md);
    s_cap_i = cap; s_bits_i = s; stat_rd_i = rd; q_wr_i = wr; q_wdata_i = wd;
    q_take_i = take; sync_i = sy; mode_i = md;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    check_all();
  endtask

  task automatic idle(logic sy, logic [3:0] md);
    cyc(0, '0, 0, 0, '0, 0, sy, md);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 status", status_o, 8'h40);
    chk("R1 q_o", {4'b0, q_o}, 8'h0f);
    chk("R1 irq", {7'b0, irq_o}, 8'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all();
    // R1 fallback is 0 after reset: enable multiframing without sync
    mode_i = 4'b0001; #1;
    chk("R1 fallback", {4'b0, q_o}, 8'h00);

    // R2/R3 capture then read, read+capture conflict
    cyc(1, 5'b10110, 0, 0, '0, 0, 0, 4'b0000);
    cyc(0, 5'b00000, 1, 0, '0, 0, 0, 4'b0000);
    cyc(1, 5'b00001, 1, 0, '0, 0, 0, 4'b0000);
    chk("R3 capture wins over read", {7'b0, status_o[5]}, 8'h1);

    // R4 sync edges, read conflict
    cyc(0, '0, 0, 0, '0, 0, 1, 4'b0000);
    cyc(0, '0, 1, 0, '0, 0, 1, 4'b0000);
    cyc(0, '0, 1, 0, '0, 0, 0, 4'b0000);
    chk("R4 edge wins over read", {7'b0, status_o[7]}, 8'h1);
    cyc(0, '0, 1, 0, '0, 0, 0, 4'b0000);

    // R5/R6 write with junk in 7:5, take, write+take conflict
    cyc(0, '0, 0, 1, 8'hE5, 0, 1, 4'b0000);
    chk("R6 stored Q bits", {4'b0, q_o}, 8'h05);
    cyc(0, '0, 0, 0, '0, 1, 1, 4'b0000);
    cyc(0, '0, 0, 1, 8'h1A, 1, 1, 4'b0000);
    chk("R5 write wins over take", {7'b0, status_o[6]}, 8'h0);
    // R7 fallback=1 on sync loss with multiframing on, not with it off
    cyc(0, '0, 1, 0, '0, 0, 0, 4'b0001);
    chk("R7 fallback used", {4'b0, q_o}, 8'h0f);
    cyc(0, '0, 1, 0, '0, 0, 0, 4'b0000);
    chk("R7 stored when mf off", {4'b0, q_o}, 8'h0a);

    // R8/R9 one enable at a time
    cyc(1, 5'b11111, 1, 0, '0, 0, 0, 4'b0100);
    idle(0, 4'b0100); idle(0, 4'b0100);
    chk("R9 irq held", {7'b0, irq_o}, 8'h1);
    cyc(0, '0, 1, 0, '0, 0, 0, 4'b0100);
    chk("R9 irq dropped", {7'b0, irq_o}, 8'h0);
    cyc(0, '0, 0, 0, '0, 1, 0, 4'b0010);
    idle(0, 4'b0010);
    cyc(0, '0, 0, 1, 8'h00, 0, 0, 4'b0010);
    cyc(0, '0, 0, 0, '0, 0, 1, 4'b1000);
    cyc(0, '0, 1, 0, '0, 0, 1, 4'b1000);
    cyc(1, 5'b11111, 0, 0, '0, 0, 1, 4'b1000);
    chk("R8 S bits give no irq", {7'b0, irq_o}, 8'h0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0] & r[1], r[6:2], r[7] & r[8], r[9] & r[10], r[18:11],
          r[19] & r[20], (r[21] & r[22]) ? ~sync_i : sync_i, r[26:23]);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule